// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block holds one 32-bit memory-mapped register for each hart in a cluster. Software on any hart writes the register that belongs to a target hart to raise, and in one variant to drop, that hart's software interrupt line. The lines are meant for inter-processor signalling. Each line comes straight from a flip-flop, so it can feed the interrupt input of its core without a combinational path from the bus.

A mode parameter picks one of two behaviours. In the read/write mode, bit 0 of each register is a pending flag. Software can set it, clear it and read it back. In the set-only mode, software can only set the flag and every read returns zero. The flag is then cleared from the target side by a one-cycle pulse on that hart's acknowledge input.

The bus is a plain register port with a byte address, 32-bit write data, four byte enables and single-cycle read and write strobes. Read data appears on the clock edge after the read strobe.

Top module: `swint_bank`

## Requirements
- R1: Hart i's register sits at byte offset 4*i. A full-word write whose data has bit 0 set raises sw_irq[i] on the clock edge that samples the write. Data bits 31..1 are ignored.
- R2: In read/write mode, a write with bit 0 clear drops sw_irq[i] on the clock edge that samples the write.
- R3: In set-only mode, a write with bit 0 clear leaves sw_irq[i] unchanged.
- R4: In read/write mode, a read of hart i returns that hart's pending flag in bit 0 and zero in bits 31..1. The value is on bus_rdata the cycle after bus_rd, and bus_rdata is zero in any cycle not following a read.
- R5: In set-only mode, bus_rdata is zero for every read.
- R6: After reset, every sw_irq line is low and bus_rdata is zero, in both modes.
- R7: In set-only mode, irq_ack[i] high for a cycle drops sw_irq[i] at that edge. In read/write mode, irq_ack has no effect.
- R8: In set-only mode, if a set write to hart i and irq_ack[i] fall in the same cycle, sw_irq[i] ends high.
- R9: An access is ignored (a write changes nothing and a read returns zero) when bus_be is not 4'b1111, when the address bits 1..0 are not zero, or when address bits above bit 1 hold a hart index of NUM_HARTS or more.
- R10: A write or acknowledge aimed at one hart leaves every other hart's line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| irq_ack | input | NUM_HARTS | Per-hart clear pulse, used only in set-only mode |
| sw_irq | output | NUM_HARTS | Per-hart software interrupt lines, from flip-flops |

## Verification
In set-only mode, a set write and a target-side acknowledge can hit the same hart's flag in one cycle. The bench drives both in the same clock period, for the same hart and for different harts, and expects the set to survive while an acknowledge on another hart still clears that hart. It also places an acknowledge on the read/write instance in the same stimulus and expects that instance's lines not to move.

// File: rtl/swint_pkg.sv
package swint_pkg;
  localparam int BUS_W = 32;
  localparam int BE_W  = BUS_W / 8;

  typedef enum logic {
    SWI_MODE_RW       = 1'b0,
    SWI_MODE_SET_ONLY = 1'b1
  } swint_mode_e;
endpackage

// File: rtl/swint_rst_sync.sv
module swint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/swint_decode.sv
module swint_decode #(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 8,
  localparam int SLOT_W   = ADDR_W - 2,
  localparam int IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [swint_pkg::BE_W-1:0] be,
  input  logic                     wr,
  output logic                     hit,
  output logic [IDX_W-1:0]         idx,
  output logic [NUM_HARTS-1:0]     wsel
);
  logic [SLOT_W-1:0] slot;
  logic              in_range;

  assign slot     = addr[ADDR_W-1:2];
  assign in_range = {{(32-SLOT_W){1'b0}}, slot} < 32'(NUM_HARTS);
  assign hit      = (be == {swint_pkg::BE_W{1'b1}}) && (addr[1:0] == 2'b00) && in_range;
  assign idx      = slot[IDX_W-1:0];

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
    assign wsel[h] = wr && hit && (slot == SLOT_W'(h));
  end
endmodule

// File: rtl/swint_cell.sv
module swint_cell #(
  parameter swint_pkg::swint_mode_e MODE = swint_pkg::SWI_MODE_RW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wsel,
  input  logic wbit,
  input  logic ack,
  output logic pend
);
  localparam bit SET_ONLY = (MODE == swint_pkg::SWI_MODE_SET_ONLY);

  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = 1'b0;
    pend_d  = pend_q;
    if (SET_ONLY) begin
      if (wsel && wbit) begin
        pend_en = 1'b1;
        pend_d  = 1'b1;
      end else if (ack) begin
        pend_en = 1'b1;
        pend_d  = 1'b0;
      end
    end else if (wsel) begin
      pend_en = 1'b1;
      pend_d  = wbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend = pend_q;

  assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel && wbit) |=> pend);
  assert_rw_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!SET_ONLY && wsel && !wbit) |=> !pend);
  assert_so_zero_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_ONLY && wsel && !wbit && !ack) |=> $stable(pend));
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_ONLY && ack && !(wsel && wbit)) |=> !pend);
  assert_rw_ack_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!SET_ONLY && !wsel) |=> $stable(pend));
  assert_set_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_ONLY && wsel && wbit && ack) |=> pend);
endmodule

// File: rtl/swint_bank.sv
module swint_bank #(
  parameter int                     NUM_HARTS = 4,
  parameter int                     ADDR_W    = 8,
  parameter swint_pkg::swint_mode_e MODE      = swint_pkg::SWI_MODE_RW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [swint_pkg::BUS_W-1:0]  bus_wdata,
  input  logic [swint_pkg::BE_W-1:0]   bus_be,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  output logic [swint_pkg::BUS_W-1:0]  bus_rdata,
  input  logic [NUM_HARTS-1:0]         irq_ack,
  output logic [NUM_HARTS-1:0]         sw_irq
);
  localparam int  IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam bit  SET_ONLY = (MODE == swint_pkg::SWI_MODE_SET_ONLY);

  logic                        rst_sync_n;
  logic                        hit;
  logic [IDX_W-1:0]            idx;
  logic [NUM_HARTS-1:0]        wsel;
  logic [NUM_HARTS-1:0]        pend;
  logic [swint_pkg::BUS_W-1:0] rdata_q, rdata_d;
  logic                        unused_wdata;

  assign unused_wdata = ^bus_wdata[swint_pkg::BUS_W-1:1];

  swint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swint_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .be   (bus_be),
    .wr   (bus_wr),
    .hit  (hit),
    .idx  (idx),
    .wsel (wsel)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    swint_cell #(.MODE(MODE)) u_cell (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .wsel (wsel[h]),
      .wbit (bus_wdata[0]),
      .ack  (irq_ack[h]),
      .pend (pend[h])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (!SET_ONLY && bus_rd && hit) rdata_d[0] = pend[idx];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign sw_irq    = pend;

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(wsel));
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[swint_pkg::BUS_W-1:1] == '0);
  assert_read_value_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!SET_ONLY && bus_rd && hit && !bus_wr) |=> (bus_rdata[0] == $past(sw_irq[idx])));
  assert_so_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    SET_ONLY |-> (bus_rdata == '0));
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |=> (bus_rdata == '0));
  assert_bad_access_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!hit && !(SET_ONLY && (irq_ack != '0))) |=> $stable(sw_irq) && (bus_rdata == '0));
endmodule

// File: tb/tb_swint_bank.sv
`timescale 1ns/1ps
module tb_swint_bank;
  localparam int NH = 4;
  localparam int AW = 6;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [3:0]    bus_be;
  logic          bus_wr, bus_rd;
  logic [31:0]   rdata_m, rdata_s;
  logic [NH-1:0] ack_m, ack_s, irq_m, irq_s;
  logic [NH-1:0] exp_m, exp_s;
  int            n_checks, n_fail;
  bit            done;

  swint_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(swint_pkg::SWI_MODE_RW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rdata_m),
    .irq_ack(ack_m), .sw_irq(irq_m));

  swint_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(swint_pkg::SWI_MODE_SET_ONLY)) dut_so (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rdata_s),
    .irq_ack(ack_s), .sw_irq(irq_s));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be,
                       input logic wr, input logic [NH-1:0] am, input logic [NH-1:0] as);
    logic [NH-1:0] setb;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = wr; bus_rd = 1'b0;
    ack_m = am; ack_s = as;
    setb = '0;
    if (wr && be == 4'hF && a[1:0] == 2'b00 && int'(a[AW-1:2]) < NH) begin
      exp_m[a[AW-1:2]] = d[0];
      setb[a[AW-1:2]] = d[0];
    end
    exp_s = (exp_s & ~as) | setb;
    @(negedge clk);
    bus_wr = 1'b0; ack_m = '0; ack_s = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [3:0] be,
                          output logic [31:0] rm, output logic [31:0] rs);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    rm = rdata_m; rs = rdata_s;
  endtask

  task automatic cmp_lines(input string tag);
    check({tag, " rw lines"}, 32'(irq_m), 32'(exp_m));
    check({tag, " so lines"}, 32'(irq_s), 32'(exp_s));
  endtask

  task automatic t_reset;
    logic [31:0] rm, rs;
    check("R6 rw lines after reset", 32'(irq_m), 32'h0);
    check("R6 so lines after reset", 32'(irq_s), 32'h0);
    check("R6 rw rdata idle", rdata_m, 32'h0);
    bus_read(6'h00, 4'hF, rm, rs);
    check("R6 rw read hart0", rm, 32'h0);
    check("R6 so read hart0", rs, 32'h0);
  endtask

  task automatic t_set_each;
    cycle(6'h04, 32'hFFFF_FFFE, 4'hF, 1'b1, '0, '0);
    cmp_lines("R1 bit0 clear sets nothing");
    for (int h = 0; h < NH; h++) begin
      cycle(AW'(4*h), 32'h0000_0001 | (32'h1 << (h + 4)), 4'hF, 1'b1, '0, '0);
      cmp_lines("R1 R10 set one hart");
    end
  endtask

  task automatic t_read_rw;
    logic [31:0] rm, rs;
    cycle(6'h08, 32'h0, 4'hF, 1'b1, '0, '0);
    for (int h = 0; h < NH; h++) begin
      bus_read(AW'(4*h), 4'hF, rm, rs);
      check("R4 rw readback", rm, 32'(exp_m[h]));
      check("R5 so reads zero", rs, 32'h0);
    end
    @(negedge clk);
    check("R4 rdata zero when idle", rdata_m, 32'h0);
  endtask

  task automatic t_clear;
    cycle(6'h00, 32'hFFFF_FFF0, 4'hF, 1'b1, '0, '0);
    check("R2 rw write0 clears", 32'(irq_m[0]), 32'h0);
    check("R3 so write0 ignored", 32'(irq_s[0]), 32'h1);
    cmp_lines("R2 R3 R10 others kept");
  endtask

  task automatic t_ack;
    cycle(6'h00, 32'h1, 4'hF, 1'b1, '0, '0);
    cycle(6'h00, 32'h0, 4'h0, 1'b0, 4'b1111, 4'b0101);
    check("R7 so ack clears 0 and 2", 32'(irq_s), 32'(exp_s));
    check("R7 rw ack ignored", 32'(irq_m), 32'(exp_m));
  endtask

  task automatic t_collide;
    cycle(6'h0C, 32'h1, 4'hF, 1'b1, '0, '0);
    cycle(6'h0C, 32'h1, 4'hF, 1'b1, 4'b1010, 4'b1010);
    check("R8 set wins over ack hart3", 32'(irq_s[3]), 32'h1);
    check("R8 R10 ack other hart clears", 32'(irq_s[1]), 32'h0);
    cmp_lines("R8 collide lines");
    cycle(6'h00, 32'h1, 4'hF, 1'b1, '0, 4'b0001);
    check("R8 set wins hart0", 32'(irq_s[0]), 32'h1);
  endtask

  task automatic t_bad;
    logic [31:0] rm, rs;
    cycle(6'h04, 32'h1, 4'hF, 1'b1, '0, '0);
    cycle(6'h00, 32'h0, 4'h1, 1'b1, '0, '0);
    cycle(6'h01, 32'h0, 4'hF, 1'b1, '0, '0);
    cycle(6'h06, 32'h0, 4'hF, 1'b1, '0, '0);
    check("R9 partial/misaligned write ignored", 32'(irq_m[0]), 32'h1);
    check("R9 misaligned hart1 write ignored", 32'(irq_m[1]), 32'h1);
    cycle(6'h10, 32'h1, 4'hF, 1'b1, '0, '0);
    cycle(6'h3C, 32'h1, 4'hF, 1'b1, '0, '0);
    cmp_lines("R9 out of range write ignored");
    bus_read(6'h02, 4'hF, rm, rs);
    check("R9 misaligned read zero", rm, 32'h0);
    bus_read(6'h00, 4'h3, rm, rs);
    check("R9 partial read zero", rm, 32'h0);
    bus_read(6'h10, 4'hF, rm, rs);
    check("R9 out of range read zero", rm, 32'h0);
    bus_read(6'h04, 4'hF, rm, rs);
    check("R4 aligned read after bad ones", rm, 32'h1);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; ack_m = '0; ack_s = '0;
    exp_m = '0; exp_s = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_each();
    t_read_rw();
    t_clear();
    t_ack();
    t_collide();
    t_bad();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule